// File: doc/BRIEF.md
# Shared RAM Region Write Protector

This block polices write requests that two bus masters, a main CPU and a coprocessor, issue into one RAM window. The window is cut into three regions: a coprocessor-private region that always starts at the lowest RAM page, a region shared by both masters, and a CPU-private region that covers every other page of the window. Region limits are 8-bit page numbers with 256-byte granularity. The page a limit names always belongs to its region.

While protection is enabled, the block blocks a CPU write into the coprocessor-private region and records it in a sticky violation flag. That flag can raise an interrupt. A coprocessor write that lands in the window outside both its own region and the shared region is suppressed and reported as an access error pulse. Reads are never blocked. For every request the block gives a registered pass or block decision that the RAM controller uses to perform or drop the access. A small register write port sets the limits, the enable, the interrupt enable and the flag clear.

Top module: `shared_ram_guard`

## Requirements
- R1: An address belongs to the RAM window when bits [22:16] equal 0x0F and its page (bits [15:8]) is at least 0x80. The coprocessor region is the set of window pages from 0x80 up to and including the coprocessor top limit.
- R2: The shared region is the set of window pages from the shared bottom limit up to and including the shared top limit, and it takes precedence over the coprocessor region. With limits 0xC1 and 0xE0 it covers 0x0FC100 through 0x0FE0FF. All other window pages form the CPU region.
- R3: With protection enabled, a CPU write into the coprocessor region gives cpu_blocked=1 and cpu_pass=0 one cycle after the request.
- R4: With protection enabled, a coprocessor write to a CPU-region address gives cop_err=1 and cop_pass=0 one cycle after the request. Coprocessor writes outside the window are not judged and pass.
- R5: A read (req=1, we=0) from either master always gives pass=1 and no block or error one cycle later.
- R6: With protection disabled, every request passes, nothing is blocked, and the violation flag is not set.
- R7: The violation flag is set at the same edge that cpu_blocked rises and stays set. Coprocessor offences do not set it.
- R8: Writing the control register with bit 7 set clears the flag. A CPU violation in the same cycle wins and leaves the flag set.
- R9: viol_irq equals the violation flag ANDed with the interrupt enable bit.
- R10: Config register select: 0 is the coprocessor top limit, 1 the shared bottom, 2 the shared top, and 3 the control register (bit 0 enable, bit 1 interrupt enable, bit 7 clear). A write applies to requests made in later cycles.
- R11: Reset sets all limits, enables, the flag and every output to 0. When no request is made, pass, blocked and err are 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU request is a write |
| cpu_addr | input | 23 | CPU global byte address |
| cop_req | input | 1 | Coprocessor access request |
| cop_we | input | 1 | Coprocessor request is a write |
| cop_addr | input | 23 | Coprocessor global byte address |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Config register select |
| cfg_wdata | input | 8 | Config write data |
| cpu_pass | output | 1 | CPU access may proceed (registered) |
| cpu_blocked | output | 1 | CPU write blocked (registered) |
| cop_pass | output | 1 | Coprocessor access may proceed (registered) |
| cop_err | output | 1 | Coprocessor write suppressed, access error (registered) |
| viol_flag | output | 1 | Sticky CPU violation flag |
| viol_irq | output | 1 | Violation interrupt request |

## Verification
Every decision output and the flag change at the first rising edge after the request is presented, and a config write changes the rules from that same edge on. The bench drives inputs on the falling edge, lets one rising edge pass and samples just after it. Before the edge it computes the expected decision from a model of the region limits, enable and flag. It then updates that model with the config write made in the same cycle, so a same-cycle config write never affects the request it accompanies.

// File: rtl/shared_ram_guard_pkg.sv
package shared_ram_guard_pkg;
  typedef enum logic [1:0] {
    RG_OUTSIDE = 2'd0,
    RG_COP     = 2'd1,
    RG_SHARED  = 2'd2,
    RG_CPU     = 2'd3
  } region_e;

  localparam logic [1:0] SEL_COP_TOP = 2'd0;
  localparam logic [1:0] SEL_SH_BOT  = 2'd1;
  localparam logic [1:0] SEL_SH_TOP  = 2'd2;
  localparam logic [1:0] SEL_CTRL    = 2'd3;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_IE  = 1;
  localparam int CTRL_CLR = 7;
endpackage

// File: rtl/srg_cfg_regs.sv
module srg_cfg_regs
  import shared_ram_guard_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [PAGE_W-1:0] cop_top,
  output logic [PAGE_W-1:0] sh_bot,
  output logic [PAGE_W-1:0] sh_top,
  output logic              prot_en,
  output logic              irq_en,
  output logic              clr_req
);
  logic ctrl_wr;
  assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
  assign clr_req = ctrl_wr && cfg_wdata[CTRL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cop_top <= '0;
      sh_bot  <= '0;
      sh_top  <= '0;
      prot_en <= 1'b0;
      irq_en  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_COP_TOP: cop_top <= cfg_wdata;
        SEL_SH_BOT:  sh_bot  <= cfg_wdata;
        SEL_SH_TOP:  sh_top  <= cfg_wdata;
        default: begin
          prot_en <= cfg_wdata[CTRL_EN];
          irq_en  <= cfg_wdata[CTRL_IE];
        end
      endcase
    end
  end
endmodule

// File: rtl/srg_region_decode.sv
module srg_region_decode
  import shared_ram_guard_pkg::*;
#(
  parameter int          ADDR_W      = 23,
  parameter int          PAGE_W      = 8,
  parameter int          OFS_W       = 8,
  parameter int unsigned WIN_HI      = 'h0F,
  parameter int unsigned RAM_LO_PAGE = 'h80
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] cop_top,
  input  logic [PAGE_W-1:0] sh_bot,
  input  logic [PAGE_W-1:0] sh_top,
  output region_e           region
);
  localparam int HI_W = ADDR_W - PAGE_W - OFS_W;
  localparam logic [HI_W-1:0]   HI_VAL = HI_W'(WIN_HI);
  localparam logic [PAGE_W-1:0] LO_PG  = PAGE_W'(RAM_LO_PAGE);

  logic [PAGE_W-1:0] page;
  logic in_win, in_sh, in_cop;

  assign page   = addr[OFS_W +: PAGE_W];
  assign in_win = (addr[ADDR_W-1 -: HI_W] == HI_VAL) && (page >= LO_PG);
  assign in_sh  = (page >= sh_bot) && (page <= sh_top);
  assign in_cop = (page <= cop_top);

  always_comb begin
    if (!in_win)     region = RG_OUTSIDE;
    else if (in_sh)  region = RG_SHARED;
    else if (in_cop) region = RG_COP;
    else             region = RG_CPU;
  end
endmodule

// File: rtl/srg_master_gate.sv
module srg_master_gate
  import shared_ram_guard_pkg::*;
#(
  parameter bit IS_COP = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    we,
  input  region_e region,
  input  logic    prot_en,
  output logic    viol,
  output logic    pass_q,
  output logic    block_q
);
  region_e forbidden;
  assign forbidden = IS_COP ? RG_CPU : RG_COP;
  assign viol = prot_en && req && we && (region == forbidden);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      pass_q  <= req && !viol;
      block_q <= viol;
    end
  end

  // R5: reads are never stopped
  assert_read_pass_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req && !we)) |-> (pass_q && !block_q));

  // R6: nothing blocked while protection is off
  assert_off_no_block_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!prot_en)) |-> !block_q);
endmodule

// File: rtl/srg_violation_flag.sv
module srg_violation_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign irq = flag_q && irq_en;

  // R8: a violation beats a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(set_req)) |-> flag_q);

  // R7: the flag only rises because of a violation
  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $rose(flag_q)) |-> $past(set_req));
endmodule

// File: rtl/shared_ram_guard.sv
module shared_ram_guard
  import shared_ram_guard_pkg::*;
#(
  parameter int          ADDR_W      = 23,
  parameter int          PAGE_W      = 8,
  parameter int          OFS_W       = 8,
  parameter int unsigned WIN_HI      = 'h0F,
  parameter int unsigned RAM_LO_PAGE = 'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cop_req,
  input  logic              cop_we,
  input  logic [ADDR_W-1:0] cop_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic              cpu_pass,
  output logic              cpu_blocked,
  output logic              cop_pass,
  output logic              cop_err,
  output logic              viol_flag,
  output logic              viol_irq
);
  localparam int N_M = 2;

  logic [PAGE_W-1:0] cop_top, sh_bot, sh_top;
  logic prot_en, irq_en, clr_req;

  logic [N_M-1:0]    m_req, m_we, m_viol, m_pass, m_block;
  logic [ADDR_W-1:0] m_addr [N_M];
  region_e           m_region [N_M];

  assign m_req[0]  = cpu_req;
  assign m_we[0]   = cpu_we;
  assign m_addr[0] = cpu_addr;
  assign m_req[1]  = cop_req;
  assign m_we[1]   = cop_we;
  assign m_addr[1] = cop_addr;

  srg_cfg_regs #(.PAGE_W(PAGE_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cop_top(cop_top), .sh_bot(sh_bot),
    .sh_top(sh_top), .prot_en(prot_en), .irq_en(irq_en), .clr_req(clr_req)
  );

  for (genvar m = 0; m < N_M; m++) begin : g_master
    srg_region_decode #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFS_W(OFS_W),
      .WIN_HI(WIN_HI), .RAM_LO_PAGE(RAM_LO_PAGE)
    ) u_dec (
      .addr(m_addr[m]), .cop_top(cop_top), .sh_bot(sh_bot),
      .sh_top(sh_top), .region(m_region[m])
    );
    srg_master_gate #(.IS_COP(m == 1)) u_gate (
      .clk(clk), .rst(rst), .req(m_req[m]), .we(m_we[m]),
      .region(m_region[m]), .prot_en(prot_en), .viol(m_viol[m]),
      .pass_q(m_pass[m]), .block_q(m_block[m])
    );
  end

  srg_violation_flag u_flag (
    .clk(clk), .rst(rst), .set_req(m_viol[0]), .clr_req(clr_req),
    .irq_en(irq_en), .flag_q(viol_flag), .irq(viol_irq)
  );

  assign cpu_pass    = m_pass[0];
  assign cpu_blocked = m_block[0];
  assign cop_pass    = m_pass[1];
  assign cop_err     = m_block[1];

  // R4: an access error only follows a coprocessor write
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cop_err) |-> $past(cop_req && cop_we));

  // R7: a blocked CPU write always leaves the flag set
  assert_block_flags_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_blocked |-> viol_flag);
endmodule

// File: tb/shared_ram_guard_test.sv
module shared_ram_guard_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0, cop_req = 0, cop_we = 0, cfg_we = 0;
  logic [22:0] cpu_addr = '0, cop_addr = '0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic cpu_pass, cpu_blocked, cop_pass, cop_err, viol_flag, viol_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_cop_top = 0, m_sh_bot = 0, m_sh_top = 0;
  logic m_en = 0, m_ie = 0, m_flag = 0;

  always #5 clk = ~clk;

  shared_ram_guard uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cop_req(cop_req), .cop_we(cop_we),
    .cop_addr(cop_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpu_pass(cpu_pass), .cpu_blocked(cpu_blocked),
    .cop_pass(cop_pass), .cop_err(cop_err), .viol_flag(viol_flag),
    .viol_irq(viol_irq)
  );

  // 0 outside, 1 coprocessor, 2 shared, 3 CPU (R1, R2)
  function automatic int region_of(logic [22:0] a);
    logic [7:0] pg;
    pg = a[15:8];
    if (a[22:16] != 7'h0F || pg < 8'h80) return 0;
    if (pg >= m_sh_bot && pg <= m_sh_top) return 2;
    if (pg <= m_cop_top) return 1;
    return 3;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, predict, let an edge pass, compare
  task automatic step(logic creq, logic cwe, logic [22:0] ca,
                      logic preq, logic pwe, logic [22:0] pa,
                      logic gwe, logic [1:0] gsel, logic [7:0] gd);
    logic e_cblk, e_perr, e_cpass, e_ppass, e_flag;
    cpu_req = creq; cpu_we = cwe; cpu_addr = ca;
    cop_req = preq; cop_we = pwe; cop_addr = pa;
    cfg_we = gwe; cfg_sel = gsel; cfg_wdata = gd;
    e_cblk  = m_en && creq && cwe && region_of(ca) == 1;
    e_perr  = m_en && preq && pwe && region_of(pa) == 3;
    e_cpass = creq && !e_cblk;
    e_ppass = preq && !e_perr;
    e_flag  = e_cblk ? 1'b1 : ((gwe && gsel == 2'd3 && gd[7]) ? 1'b0 : m_flag);
    if (gwe) begin
      case (gsel)
        2'd0: m_cop_top = gd;
        2'd1: m_sh_bot  = gd;
        2'd2: m_sh_top  = gd;
        default: begin m_en = gd[0]; m_ie = gd[1]; end
      endcase
    end
    m_flag = e_flag;
    @(posedge clk); #1;
    check(cwe ? "R3 cpu_blocked" : "R5 cpu_blocked", cpu_blocked, e_cblk);
    check(cwe ? "R3 cpu_pass" : "R5 cpu_pass", cpu_pass, e_cpass);
    check(pwe ? "R4 cop_err" : "R5 cop_err", cop_err, e_perr);
    check(pwe ? "R4 cop_pass" : "R5 cop_pass", cop_pass, e_ppass);
    check("R7 viol_flag", viol_flag, m_flag);
    check("R9 viol_irq", viol_irq, m_flag && m_ie);
    @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] s, logic [7:0] d);
    step(0, 0, '0, 0, 0, '0, 1, s, d);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    check("R11 cpu_pass", cpu_pass, 0);
    check("R11 cop_err", cop_err, 0);
    check("R11 viol_flag", viol_flag, 0);
    check("R11 viol_irq", viol_irq, 0);
    step(0, 0, '0, 0, 0, '0, 0, 0, 0);

    // R6 protection off: nothing blocked
    cfg(2'd0, 8'hA0);
    step(1, 1, 23'h0F_8500, 1, 1, 23'h0F_F000, 0, 0, 0);

    // R10 set partition: cop 0x80..0xA0, shared 0xC1..0xE0
    cfg(2'd1, 8'hC1);
    cfg(2'd2, 8'hE0);
    cfg(2'd3, 8'h01);

    // R2 shared boundaries inclusive, both masters pass
    step(1, 1, 23'h0F_C100, 1, 1, 23'h0F_E0FF, 0, 0, 0);
    step(1, 1, 23'h0F_E0FF, 1, 1, 23'h0F_C100, 0, 0, 0);
    // R2 just outside shared is CPU region: coproc error
    step(0, 0, '0, 1, 1, 23'h0F_C0FF, 0, 0, 0);
    step(0, 0, '0, 1, 1, 23'h0F_E100, 0, 0, 0);
    // R1 coprocessor top page inclusive; first CPU page beyond it
    step(1, 1, 23'h0F_A0FF, 1, 1, 23'h0F_A100, 0, 0, 0);
    // R4 coproc outside window passes
    step(0, 0, '0, 1, 1, 23'h0E_F000, 0, 0, 0);
    // R1 page below RAM is not judged
    step(1, 1, 23'h0F_7F00, 0, 0, '0, 0, 0, 0);
    // R5 reads into forbidden regions pass
    step(1, 0, 23'h0F_8000, 1, 0, 23'h0F_F000, 0, 0, 0);
    // R8 clear with simultaneous violation: set wins; enable irq too
    step(1, 1, 23'h0F_9000, 0, 0, '0, 1, 2'd3, 8'h83);
    // R8 plain clear
    cfg(2'd3, 8'h83);
    // R7 coproc offence does not set flag
    step(0, 0, '0, 1, 1, 23'h0F_F100, 0, 0, 0);
    // R10 same-cycle config does not affect that request
    step(1, 1, 23'h0F_B000, 0, 0, '0, 1, 2'd0, 8'hB5);
    step(1, 1, 23'h0F_B000, 0, 0, '0, 0, 0, 0);
    // R11 idle gives no decision
    step(0, 0, '0, 0, 0, '0, 0, 0, 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [22:0] a0, a1;
      logic [1:0] s;
      logic [7:0] d;
      logic g;
      a0 = {($urandom_range(0, 7) == 0) ? 7'h0E : 7'h0F, 8'($urandom), 8'($urandom)};
      a1 = {($urandom_range(0, 7) == 0) ? 7'h0E : 7'h0F, 8'($urandom), 8'($urandom)};
      g = ($urandom_range(0, 9) == 0);
      s = 2'($urandom);
      d = 8'($urandom);
      if (s == 2'd3 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      step(1'($urandom), 1'($urandom), a0, 1'($urandom), 1'($urandom), a1, g, s, d);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule